// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block holds the event flags of a two-sequencer serial audio peripheral and turns them into one interrupt request. Each sequencer reports four kinds of event: it has captured a word, it has lost a received word (overrun), it can take a word to send, and it ran out of words to send (underrun). A one-cycle pulse on an event input sets the matching flag. Software clears a flag by writing a one to its bit. The two "ready" flags also clear when the sequencer's data register is accessed: a data read clears receive-ready, and a data write clears transmit-ready.

An enable mask decides which flags reach the interrupt output. The mask has two write addresses: one sets bits and one clears bits. Reading either address returns the whole mask. The interrupt output is a register that holds the OR of every flag ANDed with its enable bit. Bus reads are registered, so read data appears one clock after the read strobe.

Top module: `irq_flag_unit`

## Requirements
- R1: After a synchronous active-high reset, all flags and all enable bits are 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Each flag sits at bit position 4*class + sequencer, where class is 0 for receive-ready, 1 for receive-overrun, 2 for transmit-ready and 3 for transmit-underrun. So sequencer 0 uses bits 0, 4, 8 and 12, and sequencer 1 uses bits 1, 5, 9 and 13. An event pulse sets its flag at the next clock edge. All other bits of the flag register read as 0.
- R3: Writing to the flag register (offset 0x14) clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R4: A pulse on `data_wr_strobe[s]` clears the transmit-ready flag of sequencer s (bit 8+s) and no other flag.
- R5: A pulse on `data_rd_strobe[s]` clears the receive-ready flag of sequencer s (bit 0+s) and no other flag.
- R6: The overrun and underrun flags are not cleared by data strobes. Only a write of one to their bit clears them.
- R7: If an event pulse and any clear source hit the same flag in the same cycle, the flag ends up set.
- R8: Writing to offset 0x10 sets every enable bit whose write-data bit is 1. Writing to offset 0x0C clears every enable bit whose write-data bit is 1. Reading either offset returns the enable mask in the flag bit layout. Bits outside that layout always read as 0.
- R9: `irq` equals the OR of (flag AND enable) over all bits, as they stood one clock earlier.
- R10: One clock after a cycle with `bus_rd_en` high, `bus_rdata` holds the addressed register as it stood in that read cycle. An unmapped address returns 0. One clock after a cycle with `bus_rd_en` low, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_word_evt | input | NUM_SEQ | Per-sequencer pulse: a new word was captured |
| rx_overrun_evt | input | NUM_SEQ | Per-sequencer pulse: receive overrun |
| tx_space_evt | input | NUM_SEQ | Per-sequencer pulse: ready for a new word to send |
| tx_underrun_evt | input | NUM_SEQ | Per-sequencer pulse: transmit underrun |
| data_rd_strobe | input | NUM_SEQ | Per-sequencer data register read access |
| data_wr_strobe | input | NUM_SEQ | Per-sequencer data register write access |
| irq | output | 1 | Registered interrupt request |

## Verification
A flag stuck in the wrong state shows in two places. If its enable bit is set, it shows on `irq` one clock later. It also shows in the read data one clock after a read of offset 0x14. A wrong enable bit can only be seen through a read of 0x10 or 0x0C, or through `irq` once its flag is set. For this reason the bench enables every flag before it exercises the clear paths, and it reads the flag register after each directed step. It compares `irq` and `bus_rdata` with a behavioural model on every clock, so any divergence is reported within one or two cycles of its cause.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  // Distance between event classes in the register bit layout.
  localparam int LANE_STRIDE = 4;
  localparam int NUM_CLASS   = 4;

  typedef enum logic [1:0] {
    EV_RX_READY    = 2'd0,
    EV_RX_OVERRUN  = 2'd1,
    EV_TX_READY    = 2'd2,
    EV_TX_UNDERRUN = 2'd3
  } ev_class_e;

  function automatic int flag_pos(input int cls, input int seq);
    return cls * LANE_STRIDE + seq;
  endfunction

endpackage

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_flag_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FLAG_OFS  = 'h14,
  parameter int unsigned ENSET_OFS = 'h10,
  parameter int unsigned ENCLR_OFS = 'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] flag_q,
  input  logic [DATA_W-1:0] en_q,
  output logic [DATA_W-1:0] flag_w1c,
  output logic [DATA_W-1:0] en_set,
  output logic [DATA_W-1:0] en_clr,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam logic [ADDR_W-1:0] FLAG_A  = ADDR_W'(FLAG_OFS);
  localparam logic [ADDR_W-1:0] ENSET_A = ADDR_W'(ENSET_OFS);
  localparam logic [ADDR_W-1:0] ENCLR_A = ADDR_W'(ENCLR_OFS);

  logic hit_flag, hit_set, hit_clr;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    hit_flag = (bus_addr == FLAG_A);
    hit_set  = (bus_addr == ENSET_A);
    hit_clr  = (bus_addr == ENCLR_A);
    flag_w1c = (bus_wr_en && hit_flag) ? bus_wdata : '0;
    en_set   = (bus_wr_en && hit_set)  ? bus_wdata : '0;
    en_clr   = (bus_wr_en && hit_clr)  ? bus_wdata : '0;
    if (hit_flag)                rd_mux = flag_q;
    else if (hit_set || hit_clr) rd_mux = en_q;
    else                         rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
    else                bus_rdata <= '0;
  end

  // R10: an idle read cycle leaves zero on the read bus
  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> (bus_rdata == '0));

  // R10: a flag-register read returns the flags of the read cycle
  p_rdata_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == FLAG_A) |=> (bus_rdata == $past(flag_q)));

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_flag_pkg::*;
#(
  parameter int unsigned NUM_SEQ = 2,
  parameter int unsigned DATA_W  = 16,
  parameter logic [DATA_W-1:0] IMPL = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SEQ-1:0] rx_word_evt,
  input  logic [NUM_SEQ-1:0] rx_overrun_evt,
  input  logic [NUM_SEQ-1:0] tx_space_evt,
  input  logic [NUM_SEQ-1:0] tx_underrun_evt,
  input  logic [NUM_SEQ-1:0] data_rd_strobe,
  input  logic [NUM_SEQ-1:0] data_wr_strobe,
  input  logic [DATA_W-1:0]  flag_w1c,
  output logic [DATA_W-1:0]  flag_q
);

  logic [DATA_W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    clr_vec = flag_w1c & IMPL;
    for (int s = 0; s < int'(NUM_SEQ); s++) begin
      set_vec[flag_pos(EV_RX_READY, s)]    = rx_word_evt[s];
      set_vec[flag_pos(EV_RX_OVERRUN, s)]  = rx_overrun_evt[s];
      set_vec[flag_pos(EV_TX_READY, s)]    = tx_space_evt[s];
      set_vec[flag_pos(EV_TX_UNDERRUN, s)] = tx_underrun_evt[s];
      clr_vec[flag_pos(EV_RX_READY, s)] = clr_vec[flag_pos(EV_RX_READY, s)] | data_rd_strobe[s];
      clr_vec[flag_pos(EV_TX_READY, s)] = clr_vec[flag_pos(EV_TX_READY, s)] | data_wr_strobe[s];
    end
  end

  // Set has priority so an event coinciding with a clear is kept.
  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (set_vec | (flag_q & ~clr_vec)) & IMPL;
  end

  for (genvar b = 0; b < int'(DATA_W); b++) begin : g_chk
    if (IMPL[b]) begin : g_impl
      // R7: an event always lands, whatever clears arrive with it
      p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        set_vec[b] |=> flag_q[b]);
      // R3: a clear without an event empties the flag
      p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_vec[b] && !set_vec[b]) |=> !flag_q[b]);
      // R6: with no set or clear source, the flag holds
      p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr_vec[b] && !set_vec[b]) |=> $stable(flag_q[b]));
    end else begin : g_unimpl
      // R2: bits outside the layout never set
      p_unimpl_r2: assert property (@(posedge clk) disable iff (rst)
        !flag_q[b]);
    end
  end

endmodule

// File: rtl/irq_enable_mask.sv
module irq_enable_mask #(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] IMPL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] en_set,
  input  logic [DATA_W-1:0] en_clr,
  output logic [DATA_W-1:0] en_q
);

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= ((en_q | en_set) & ~en_clr) & IMPL;
  end

  for (genvar b = 0; b < int'(DATA_W); b++) begin : g_chk
    if (IMPL[b]) begin : g_impl
      // R8: a one written to the set address enables the bit
      p_en_set_r8: assert property (@(posedge clk) disable iff (rst)
        (en_set[b] && !en_clr[b]) |=> en_q[b]);
      // R8: a one written to the clear address disables the bit
      p_en_clr_r8: assert property (@(posedge clk) disable iff (rst)
        en_clr[b] |=> !en_q[b]);
    end
  end

endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_flag_pkg::*;
#(
  parameter int unsigned NUM_SEQ   = 2,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FLAG_OFS  = 'h14,
  parameter int unsigned ENSET_OFS = 'h10,
  parameter int unsigned ENCLR_OFS = 'h0C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr_en,
  input  logic               bus_rd_en,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SEQ-1:0] rx_word_evt,
  input  logic [NUM_SEQ-1:0] rx_overrun_evt,
  input  logic [NUM_SEQ-1:0] tx_space_evt,
  input  logic [NUM_SEQ-1:0] tx_underrun_evt,
  input  logic [NUM_SEQ-1:0] data_rd_strobe,
  input  logic [NUM_SEQ-1:0] data_wr_strobe,
  output logic               irq
);

  function automatic logic [DATA_W-1:0] impl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CLASS; c++)
      for (int s = 0; s < int'(NUM_SEQ); s++)
        m[flag_pos(c, s)] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] IMPL = impl_mask();

  logic [DATA_W-1:0] flag_q, en_q, flag_w1c, en_set, en_clr;

  irq_reg_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FLAG_OFS(FLAG_OFS), .ENSET_OFS(ENSET_OFS), .ENCLR_OFS(ENCLR_OFS)
  ) u_port (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_wdata(bus_wdata), .flag_q(flag_q), .en_q(en_q),
    .flag_w1c(flag_w1c), .en_set(en_set), .en_clr(en_clr),
    .bus_rdata(bus_rdata)
  );

  irq_flag_bank #(.NUM_SEQ(NUM_SEQ), .DATA_W(DATA_W), .IMPL(IMPL)) u_flags (
    .clk(clk), .rst(rst),
    .rx_word_evt(rx_word_evt), .rx_overrun_evt(rx_overrun_evt),
    .tx_space_evt(tx_space_evt), .tx_underrun_evt(tx_underrun_evt),
    .data_rd_strobe(data_rd_strobe), .data_wr_strobe(data_wr_strobe),
    .flag_w1c(flag_w1c), .flag_q(flag_q)
  );

  irq_enable_mask #(.DATA_W(DATA_W), .IMPL(IMPL)) u_mask (
    .clk(clk), .rst(rst), .en_set(en_set), .en_clr(en_clr), .en_q(en_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flag_q & en_q);
  end

  // R9: an enabled pending flag raises irq on the next clock
  p_irq_up_r9: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & en_q)) |=> irq);
  // R9: with nothing enabled and pending, irq drops on the next clock
  p_irq_down_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & en_q)) |=> !irq);

endmodule

// File: tb/irq_flag_unit_test.sv
`timescale 1ns/1ps
module irq_flag_unit_test;

  localparam int NS = 2;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] A_FLAG = 8'h14;
  localparam logic [AW-1:0] A_SET  = 8'h10;
  localparam logic [AW-1:0] A_CLR  = 8'h0C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NS-1:0] rx_word_evt = '0, rx_overrun_evt = '0, tx_space_evt = '0, tx_underrun_evt = '0;
  logic [NS-1:0] data_rd_strobe = '0, data_wr_strobe = '0;
  logic irq;

  int checks = 0;
  int errors = 0;

  // model state
  logic [DW-1:0] m_flag = '0, m_en = '0, m_rdata = '0;
  logic m_irq = 1'b0;

  always #2 clk = ~clk;

  irq_flag_unit uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_word_evt(rx_word_evt), .rx_overrun_evt(rx_overrun_evt),
    .tx_space_evt(tx_space_evt), .tx_underrun_evt(tx_underrun_evt),
    .data_rd_strobe(data_rd_strobe), .data_wr_strobe(data_wr_strobe),
    .irq(irq)
  );

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock: advance the model from current inputs, then compare outputs.
  task automatic tick(input string tag);
    logic [DW-1:0] nf, ne, nr;
    logic ni;
    int bit_i;
    if (rst) begin
      nf = '0; ne = '0; nr = '0; ni = 1'b0;
    end else begin
      ni = |(m_flag & m_en);
      nr = '0;
      if (bus_rd_en) begin
        if (bus_addr == A_FLAG) nr = m_flag;
        else if (bus_addr == A_SET || bus_addr == A_CLR) nr = m_en;
      end
      ne = m_en;
      nf = m_flag;
      for (int c = 0; c < 4; c++) begin
        for (int s = 0; s < NS; s++) begin
          bit_i = 4 * c + s;
          if (bus_wr_en && bus_addr == A_SET && bus_wdata[bit_i]) ne[bit_i] = 1'b1;
          if (bus_wr_en && bus_addr == A_CLR && bus_wdata[bit_i]) ne[bit_i] = 1'b0;
          if (bus_wr_en && bus_addr == A_FLAG && bus_wdata[bit_i]) nf[bit_i] = 1'b0;
          if (c == 0 && data_rd_strobe[s]) nf[bit_i] = 1'b0;
          if (c == 2 && data_wr_strobe[s]) nf[bit_i] = 1'b0;
          case (c)
            0: if (rx_word_evt[s])     nf[bit_i] = 1'b1;
            1: if (rx_overrun_evt[s])  nf[bit_i] = 1'b1;
            2: if (tx_space_evt[s])    nf[bit_i] = 1'b1;
            default: if (tx_underrun_evt[s]) nf[bit_i] = 1'b1;
          endcase
        end
      end
    end
    @(posedge clk);
    #1;
    m_flag = nf; m_en = ne; m_rdata = nr; m_irq = ni;
    chk(tag, "bus_rdata", bus_rdata, m_rdata);
    chk(tag, "irq", {15'b0, irq}, {15'b0, m_irq});
  endtask

  task automatic idle();
    bus_wr_en = 1'b0; bus_rd_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_word_evt = '0; rx_overrun_evt = '0; tx_space_evt = '0; tx_underrun_evt = '0;
    data_rd_strobe = '0; data_wr_strobe = '0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    tick(tag);
    idle();
  endtask

  // Read, then compare the returned word with an explicit expectation.
  task automatic rd_expect(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    bus_addr = a; bus_rd_en = 1'b1;
    tick(tag);
    idle();
    chk(tag, "read value", bus_rdata, exp);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    for (int i = 0; i < 3; i++) tick("R1");
    rst = 1'b0;
    chk("R1", "irq after reset", {15'b0, irq}, 16'h0000);
    chk("R1", "rdata after reset", bus_rdata, 16'h0000);
    rd_expect(A_FLAG, 16'h0000, "R1");
    rd_expect(A_SET, 16'h0000, "R1");

    // R2: each event sets its own bit; irq stays low while masked
    rx_word_evt = 2'b01; tick("R2"); idle();
    rd_expect(A_FLAG, 16'h0001, "R2");
    rx_overrun_evt = 2'b10; tick("R2"); idle();
    tx_space_evt = 2'b01; tick("R2"); idle();
    tx_underrun_evt = 2'b10; tick("R2"); idle();
    rd_expect(A_FLAG, 16'h2121, "R2");
    rx_word_evt = 2'b10; rx_overrun_evt = 2'b01; tx_space_evt = 2'b10; tx_underrun_evt = 2'b01;
    tick("R2"); idle();
    rd_expect(A_FLAG, 16'h3333, "R2");
    chk("R9", "irq masked", {15'b0, irq}, 16'h0000);

    // R8: enable set/clear addresses and unimplemented bits
    wr(A_SET, 16'hFFFF, "R8");
    rd_expect(A_CLR, 16'h3333, "R8");
    wr(A_CLR, 16'h0F0F, "R8");
    rd_expect(A_SET, 16'h3030, "R8");
    wr(A_SET, 16'h0303, "R8");
    rd_expect(A_SET, 16'h3333, "R8");
    tick("R9");
    chk("R9", "irq enabled", {15'b0, irq}, 16'h0001);

    // R3: writing zeros changes nothing; ones clear
    wr(A_FLAG, 16'h0000, "R3");
    rd_expect(A_FLAG, 16'h3333, "R3");
    wr(A_FLAG, 16'h1010, "R3");
    rd_expect(A_FLAG, 16'h2323, "R3");

    // R4: data write strobe clears only that sequencer's transmit-ready
    data_wr_strobe = 2'b10; tick("R4"); idle();
    rd_expect(A_FLAG, 16'h2123, "R4");
    // R5: data read strobe clears only that sequencer's receive-ready
    data_rd_strobe = 2'b01; tick("R5"); idle();
    rd_expect(A_FLAG, 16'h2122, "R5");
    // R6: strobes leave overrun/underrun alone
    data_rd_strobe = 2'b11; data_wr_strobe = 2'b11; tick("R6"); idle();
    rd_expect(A_FLAG, 16'h2020, "R6");
    wr(A_FLAG, 16'h2020, "R6");
    rd_expect(A_FLAG, 16'h0000, "R6");
    tick("R9");
    chk("R9", "irq dropped", {15'b0, irq}, 16'h0000);

    // R7: set beats write-one-clear and data strobes in the same cycle
    rx_word_evt = 2'b11; tx_space_evt = 2'b11; data_rd_strobe = 2'b11; data_wr_strobe = 2'b11;
    bus_addr = A_FLAG; bus_wdata = 16'hFFFF; bus_wr_en = 1'b1;
    tick("R7"); idle();
    rd_expect(A_FLAG, 16'h0303, "R7");

    // R10: unmapped address reads zero; idle read bus is zero
    rd_expect(8'h04, 16'h0000, "R10");
    tick("R10");
    chk("R10", "idle rdata", bus_rdata, 16'h0000);

    // R9: mixed random traffic compared cycle by cycle
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 3);
      bus_addr = (sel == 0) ? A_FLAG : (sel == 1) ? A_SET : (sel == 2) ? A_CLR : 8'h04;
      bus_wdata = 16'($urandom);
      bus_wr_en = ($urandom_range(0, 3) == 0);
      bus_rd_en = ($urandom_range(0, 1) == 0);
      rx_word_evt = 2'($urandom); rx_overrun_evt = 2'($urandom_range(0, 3) == 0);
      tx_space_evt = 2'($urandom); tx_underrun_evt = 2'($urandom_range(0, 3) == 0);
      data_rd_strobe = 2'($urandom); data_wr_strobe = 2'($urandom);
      tick("R9");
    end
    idle();
    tick("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule